// File: doc/BRIEF.md
# Dual-Line Readback SPI Target

This block is an SPI target that runs in clock mode 3 (SCLK idles high, data is captured on the rising edge and changed on the falling edge). A host opens a frame by pulling chip select low and sends one command byte. A store command puts every following byte into an internal 1024-byte buffer, starting at address 0. A fetch command streams the buffer back, also from address 0, with the address moving up by one for each byte.

Readback has two widths. In single-line mode one bit leaves per SCLK on line IO1. In dual-line mode two bits leave per SCLK on IO1 and IO0, so reading takes half the clocks. The host always sends on one line, in both modes.

The SPI pins are synchronised into the system clock domain. Outgoing data is launched on the falling SCLK edge, so the first data bit is already waiting for the host's first capture edge and no bit slip can occur. The system clock must run at least eight times faster than SCLK.

Top module: `spi_dual_readback`

## Requirements
- R1: While reset is high, and after it is released with chip select high, both output enables are 0.
- R2: When chip select is high, both lines are undriven and the bit counters clear. Every new frame starts storing and fetching at address 0.
- R3: Command byte 0x02 (MSB first on MOSI) stores each following complete byte at consecutive addresses, starting at 0.
- R4: Command byte 0x03 returns the stored bytes in address order from address 0. Outputs change only on falling SCLK edges. In single-line mode each byte goes out MSB first on IO1, and only IO1 is driven (output enable 2'b10).
- R5: In dual-line mode each SCLK carries two bits. The higher-order bit is on IO1 and the lower-order bit is on IO0, so a byte takes four SCLK periods. Both enables are 1 (2'b11), and IO0 is never driven without IO1.
- R6: The first data bit of a fetch is launched on the falling edge right after the 8th rising edge of the command byte. A stored 0x80 is read back as 0x80, with no one-position shift.
- R7: The mode input is sampled only while chip select is high. Changing it during a frame has no effect on that frame.
- R8: The address counter wraps after 1024 bytes. The 1025th byte of one store frame overwrites address 0.
- R9: Any other command byte stores nothing and leaves both lines undriven for the rest of the frame.
- R10: A byte that is incomplete when chip select rises is discarded. This includes the case where chip select rises in the same system cycle as the 8th rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the host, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-target data line |
| dual_sel | input | 1 | 1 selects dual-line readback, 0 selects single-line |
| io_out | output | 2 | Readback data: bit 1 drives IO1, bit 0 drives IO0 |
| io_oe | output | 2 | Per-line output enable for io_out (0 means tri-stated) |

## Verification
The case that matters most is two events landing in the same system cycle: the completing rising SCLK edge of a byte and the release of chip select. Both pass through synchronisers of equal depth. The bench provokes this by raising SCLK and chip select in the same cycle on the 8th bit of a store byte. It then judges the result by fetching the address that byte would have written and expecting the value stored there earlier. A second overlap is tested by flipping the mode input right after the command byte: the readback width must not change in mid-frame.

// File: rtl/spi_drb_pkg.sv
package spi_drb_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_STORE = 8'h02;
    localparam logic [BYTE_W-1:0] OP_FETCH = 8'h03;

    // frame phase after the command byte
    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_SKIP  = 2'd3
    } phase_e;

    // synchronised pin bundle, MSB first: cs_n, sclk, mosi, dual
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic mosi;
        logic dual;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b1, mosi: 1'b0, dual: 1'b0};

    function automatic phase_e decode_op(input logic [BYTE_W-1:0] op);
        case (op)
            OP_STORE: return PH_WRITE;
            OP_FETCH: return PH_READ;
            default:  return PH_SKIP;
        endcase
    endfunction

    // remaining shift count after loading a byte
    function automatic logic [2:0] last_slot(input logic dual);
        return dual ? 3'd3 : 3'd7;
    endfunction

endpackage

// File: rtl/spi_drb_sync.sv
module spi_drb_sync #(
    parameter int            W      = 4,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  RST    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spi_drb_buf.sv
module spi_drb_buf #(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rq
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        rq <= mem[ra];
    end
endmodule

// File: rtl/spi_drb_engine.sv
module spi_drb_engine
    import spi_drb_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins,
    input  logic [BYTE_W-1:0] rd_q,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [AW-1:0]     rd_addr,
    output logic [1:0]        io_out,
    output logic [1:0]        io_oe
);
    phase_e            phase;
    logic              sclk_d;
    logic [2:0]        rx_cnt;
    logic [6:0]        rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [2:0]        tx_cnt;
    logic              dual_q;

    logic              cs_hi, rise, fall, byte_done;
    logic [BYTE_W-1:0] rx_byte;

    assign cs_hi     = pins.cs_n;
    assign rise      = pins.sclk & ~sclk_d & ~cs_hi;
    assign fall      = ~pins.sclk & sclk_d & ~cs_hi;
    assign rx_byte   = {rx_sr, pins.mosi};
    assign byte_done = rise && (rx_cnt == 3'd7);

    assign wr_en   = byte_done && (phase == PH_WRITE);
    assign wr_data = rx_byte;

    assign io_out = {tx_sr[7], dual_q ? tx_sr[6] : 1'b0};
    assign io_oe  = {phase == PH_READ, (phase == PH_READ) && dual_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b1;
            phase   <= PH_CMD;
            rx_cnt  <= '0;
            rx_sr   <= '0;
            wr_addr <= '0;
            rd_addr <= '0;
            tx_sr   <= '0;
            tx_cnt  <= '0;
            dual_q  <= 1'b0;
        end else begin
            sclk_d <= pins.sclk;
            if (cs_hi) begin
                phase   <= PH_CMD;
                rx_cnt  <= '0;
                rx_sr   <= '0;
                wr_addr <= '0;
                rd_addr <= '0;
                tx_sr   <= '0;
                tx_cnt  <= '0;
                dual_q  <= pins.dual;
            end else begin
                if (rise) begin
                    rx_cnt <= rx_cnt + 3'd1;
                    rx_sr  <= rx_byte[6:0];
                end
                if (byte_done && phase == PH_CMD) phase <= decode_op(rx_byte);
                if (wr_en) wr_addr <= wr_addr + 1'b1;
                if (fall && phase == PH_READ) begin
                    if (tx_cnt == 3'd0) begin
                        tx_sr   <= rd_q;
                        rd_addr <= rd_addr + 1'b1;
                        tx_cnt  <= last_slot(dual_q);
                    end else begin
                        tx_sr  <= dual_q ? {tx_sr[5:0], 2'b00} : {tx_sr[6:0], 1'b0};
                        tx_cnt <= tx_cnt - 3'd1;
                    end
                end
            end
        end
    end

    // R2
    cs_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> (rx_cnt == 3'd0 && io_oe == 2'b00));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_hi |=> $stable(dual_q));

    // R8
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wr_addr == AW'($past(wr_addr) + 1'b1)));

    // R5
    io0_needs_io1_chk: assert property (@(posedge clk) disable iff (rst)
        io_oe[0] |-> io_oe[1]);

    // R9
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> (!wr_en && io_oe == 2'b00));

    // R4
    launch_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ && !cs_hi && !fall) |=> $stable(io_out));
endmodule

// File: rtl/spi_dual_readback.sv
module spi_dual_readback
    import spi_drb_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       dual_sel,
    output logic [1:0] io_out,
    output logic [1:0] io_oe
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $bits(pins_t);

    pins_t             raw, syn;
    logic [PW-1:0]     syn_bits;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_q;

    assign raw = '{cs_n: spi_cs_n, sclk: spi_sclk, mosi: spi_mosi, dual: dual_sel};
    assign syn = pins_t'(syn_bits);

    spi_drb_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST(PW'(PINS_IDLE))) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (PW'(raw)),
        .q   (syn_bits)
    );

    spi_drb_engine #(.DEPTH(DEPTH)) i_engine (
        .clk     (clk),
        .rst     (rst),
        .pins    (syn),
        .rd_q    (rd_q),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .io_out  (io_out),
        .io_oe   (io_oe)
    );

    spi_drb_buf #(.DEPTH(DEPTH), .DW(BYTE_W)) i_buf (
        .clk (clk),
        .we  (wr_en),
        .wa  (wr_addr),
        .wd  (wr_data),
        .ra  (rd_addr),
        .rq  (rd_q)
    );
endmodule

// File: tb/test_spi_dual_readback.sv
module test_spi_dual_readback;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b1;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       dual_sel = 1'b0;
    logic [1:0] io_out, io_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic       oe_clr = 1'b0;
    logic [1:0] oe_seen = 2'b00;

    logic [7:0] tx_buf [0:1024];
    logic [7:0] rx_buf [0:15];

    // {dual, data}
    localparam logic [8:0] VEC [0:7] = '{9'h080, 9'h101, 9'h0FF, 9'h100,
                                         9'h0A5, 9'h15A, 9'h03C, 9'h1C3};

    always #10 clk = ~clk;

    spi_dual_readback i_spi_dual_readback (
        .clk      (clk),
        .rst      (rst),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .dual_sel (dual_sel),
        .io_out   (io_out),
        .io_oe    (io_oe)
    );

    always @(posedge clk) begin
        if (oe_clr) oe_seen <= 2'b00;
        else        oe_seen <= oe_seen | io_oe;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sclk_cycle(input logic mo, output logic [1:0] smp);
        spi_sclk = 1'b0;
        spi_mosi = mo;
        repeat (H) @(negedge clk);
        smp = io_out;
        spi_sclk = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] op, input int n, input logic rd,
                             input logic dl, input logic flip);
        logic [1:0] s;
        logic [7:0] b;
        @(negedge clk);
        dual_sel = dl;
        oe_clr = 1'b1;
        repeat (3) @(negedge clk);
        oe_clr = 1'b0;
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--) sclk_cycle(op[i], s);
        if (flip) dual_sel = ~dual_sel;
        for (int k = 0; k < n; k++) begin
            b = '0;
            if (rd && dl) begin
                for (int j = 0; j < 4; j++) begin
                    sclk_cycle(1'b0, s);
                    b = {b[5:0], s[1], s[0]};
                end
                rx_buf[k] = b;
            end else if (rd) begin
                for (int j = 0; j < 8; j++) begin
                    sclk_cycle(1'b0, s);
                    b = {b[6:0], s[1]};
                end
                rx_buf[k] = b;
            end else begin
                for (int j = 7; j >= 0; j--) sclk_cycle(tx_buf[k][j], s);
            end
        end
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
    endtask

    initial begin
        logic [1:0] s;
        repeat (3) @(negedge clk);
        // R1: enables low during reset
        check("R1 oe in reset", {6'd0, io_oe}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 oe after reset", {6'd0, io_oe}, 8'h00);

        // R3 store the table in one frame, then R4/R5/R6 fetch in mixed modes
        for (int i = 0; i < 8; i++) tx_buf[i] = VEC[i][7:0];
        run_frame(8'h02, 8, 1'b0, 1'b0, 1'b0);
        check("R9 store frame leaves lines undriven", {6'd0, oe_seen}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            run_frame(8'h03, i + 1, 1'b1, VEC[i][8], 1'b0);
            check(VEC[i][8] ? "R5 dual fetch data" : "R4 R6 single fetch data",
                  rx_buf[i], VEC[i][7:0]);
            check(VEC[i][8] ? "R5 dual enables" : "R4 single enables",
                  {6'd0, oe_seen}, VEC[i][8] ? 8'h03 : 8'h02);
        end
        check("R6 first byte 0x80 unshifted", rx_buf[0], 8'h80);

        // R2: new store frame restarts at address 0
        tx_buf[0] = 8'h77;
        run_frame(8'h02, 1, 1'b0, 1'b0, 1'b0);
        run_frame(8'h03, 2, 1'b1, 1'b1, 1'b0);
        check("R2 restart address 0", rx_buf[0], 8'h77);
        check("R2 neighbour untouched", rx_buf[1], 8'h01);
        check("R2 oe idle after frame", {6'd0, io_oe}, 8'h00);

        // R8: 1025 bytes wrap onto address 0
        for (int k = 0; k < 1024; k++) tx_buf[k] = 8'(k) ^ 8'h5A;
        tx_buf[1024] = 8'hC3;
        run_frame(8'h02, 1025, 1'b0, 1'b0, 1'b0);
        run_frame(8'h03, 2, 1'b1, 1'b0, 1'b0);
        check("R8 wrap overwrites address 0", rx_buf[0], 8'hC3);
        check("R8 address 1 kept", rx_buf[1], 8'h5B);

        // R10: CS rises together with the 8th rising SCLK edge
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--) sclk_cycle(OP2_BIT(i), s);
        for (int j = 0; j < 7; j++) sclk_cycle(1'b0, s);
        spi_sclk = 1'b0;
        repeat (H) @(negedge clk);
        spi_sclk = 1'b1;
        spi_cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
        run_frame(8'h03, 1, 1'b1, 1'b0, 1'b0);
        check("R10 partial byte discarded", rx_buf[0], 8'hC3);

        // R9: unknown command
        tx_buf[0] = 8'h11;
        run_frame(8'h05, 1, 1'b0, 1'b0, 1'b0);
        check("R9 no drive on unknown op", {6'd0, oe_seen}, 8'h00);
        run_frame(8'h03, 1, 1'b1, 1'b1, 1'b0);
        check("R9 nothing stored", rx_buf[0], 8'hC3);

        // R7: mode flipped mid-frame is ignored
        run_frame(8'h03, 2, 1'b1, 1'b0, 1'b1);
        check("R7 single width kept", rx_buf[1], 8'h5B);
        check("R7 enables stay single", {6'd0, oe_seen}, 8'h02);
        dual_sel = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic OP2_BIT(input int i);
        logic [7:0] op;
        op = 8'h02;
        return op[i];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule